// File: doc/BRIEF.md
# Indexed-Access Multi-Core Timer Controller

This block is the global controller for a bank of per-core free-running 64-bit counters. Software never sees its internal registers directly. It writes an internal register number into a small index register, then reads or writes a data register that stands for the selected internal register. Two internal registers exist: a global control word and a per-core interrupt mask.

The control word holds one master enable and a one-hot prescaler select. A single write that sets the enable starts every core's counter on the same clock. The prescaler divides the block clock into the counter tick. For example, a 26 MHz clock with divide-by-2 selected gives a 13 MHz count rate. Each core also has an interrupt line. It pulses when that core's counter crosses a 2^MATCH_W boundary and the core is unmasked. Software silences interrupts through the mask alone and never has to stop the counters.

Top module: `corectr_top`

## Requirements
- R1: After reset every counter reads zero, every interrupt line is low, the index register reads zero, and the control word and mask both read zero.
- R2: A write at bus offset 0x4 loads the index register. A read at offset 0x4 returns its last written IDX_W-bit value, with the upper bits zero.
- R3: Bus offset 0x0 reads and writes the internal register chosen by the index. Index 0x00 is the control word: bit 0 is the enable and bits 10:8 are the prescaler select. All other bits of the control word are dropped on write and read as zero.
- R4: While the enable is 0, all counters hold their value. While it is 1, every core's counter advances on each prescaler tick, and all counters always hold the same value.
- R5: Prescaler select 3'b001 divides by 1, 3'b010 by 2 and 3'b100 by 4. If the enable was 0 before it is set, a counter has advanced by floor(n/div) n cycles after the write that sets the enable.
- R6: A prescaler select with no bit set, or with more than one bit set, divides by 1.
- R7: Index 0x30 is the interrupt mask, with bit c belonging to core c. A set bit lets core c's interrupt line pulse high for exactly one cycle, in the cycle in which the counter's low MATCH_W bits have just become zero.
- R8: Clearing a mask bit keeps that core's interrupt line low while the counters keep running.
- R9: At any other index, a data read returns zero and a data write changes neither the control word, the mask nor the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock and prescaler input |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register window |
| addr_i | input | ADDR_W (3) | Bus offset: 0x0 is the data register, 0x4 is the index register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for addr_i (combinational) |
| count_o | output | N_CORES*CNT_W (256) | Per-core counter values, core c in bits c*CNT_W upward |
| irq_o | output | N_CORES (4) | Per-core interrupt pulses |

## Verification
A wrong prescaler phase or divide decode shows on count_o within one to four cycles of the enable write. The bench compares every counter against its own model on every clock. A corrupted index register shows up in the same cycle on the next data read, or as a write that lands in the wrong internal register. A wrong mask bit or a wrong match point appears as an interrupt pulse on the wrong core or in the wrong cycle within one counter wrap of 2^MATCH_W ticks. The bench also counts pulses over a fixed window.

// File: rtl/corectr_pkg.sv
package corectr_pkg;
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_IDX  = 4;
  localparam int unsigned IDX_CTRL = 'h00;
  localparam int unsigned IDX_MASK = 'h30;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned PSC_LO   = 8;
  localparam int unsigned PSC_HI   = 10;
  localparam int unsigned PSC_W    = PSC_HI - PSC_LO + 1;

  // divide minus one; invalid one-hot codes fall back to divide-by-1
  function automatic logic [1:0] psc_limit(input logic [PSC_W-1:0] sel);
    unique case (sel)
      3'b010:  psc_limit = 2'd1;
      3'b100:  psc_limit = 2'd3;
      default: psc_limit = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/corectr_regwin.sv
module corectr_regwin
  import corectr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned N_CORES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               en_o,
  output logic [PSC_W-1:0]   psc_o,
  output logic [N_CORES-1:0] mask_o
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_IDX  = ADDR_W'(OFS_IDX);
  localparam logic [IDX_W-1:0]  I_CTRL = IDX_W'(IDX_CTRL);
  localparam logic [IDX_W-1:0]  I_MASK = IDX_W'(IDX_MASK);

  logic [IDX_W-1:0]   idx_q;
  logic               en_q;
  logic [PSC_W-1:0]   psc_q;
  logic [N_CORES-1:0] mask_q;

  wire hit_idx  = wr_en_i && (addr_i == A_IDX);
  wire hit_data = wr_en_i && (addr_i == A_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      en_q   <= 1'b0;
      psc_q  <= '0;
      mask_q <= '0;
    end else begin
      if (hit_idx) idx_q <= wdata_i[IDX_W-1:0];
      if (hit_data && idx_q == I_CTRL) begin
        en_q  <= wdata_i[EN_BIT];
        psc_q <= wdata_i[PSC_HI:PSC_LO];
      end
      if (hit_data && idx_q == I_MASK) mask_q <= wdata_i[N_CORES-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_IDX) begin
      rdata_o[IDX_W-1:0] = idx_q;
    end else if (addr_i == A_DATA) begin
      if (idx_q == I_CTRL) begin
        rdata_o[EN_BIT]        = en_q;
        rdata_o[PSC_HI:PSC_LO] = psc_q;
      end else if (idx_q == I_MASK) begin
        rdata_o[N_CORES-1:0] = mask_q;
      end
    end
  end

  assign en_o   = en_q;
  assign psc_o  = psc_q;
  assign mask_o = mask_q;

  // R2
  idx_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_idx |=> idx_q == $past(wdata_i[IDX_W-1:0]));
  // R9
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_data && idx_q != I_CTRL && idx_q != I_MASK) |=>
      ($stable(en_q) && $stable(psc_q) && $stable(mask_q)));
endmodule

// File: rtl/corectr_presc.sv
module corectr_presc
  import corectr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] sel_i,
  output logic             tick_o
);
  logic [1:0] phase_q;
  logic [1:0] limit;

  assign limit  = psc_limit(sel_i);
  assign tick_o = en_i && (phase_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= '0;
    else if (!en_i || tick_o)   phase_q <= '0;
    else                        phase_q <= phase_q + 2'd1;
  end

  // R5
  div4_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i == 3'b100) |=> (!tick_o || sel_i != 3'b100));
  // R5
  div2_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i == 3'b010) |=> (!tick_o || sel_i != 3'b010));
endmodule

// File: rtl/corectr_counter.sv
module corectr_counter #(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned MATCH_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             mask_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
      irq_q <= tick_i && mask_i && (&cnt_q[MATCH_W-1:0]);
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  // R4
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  // R7
  irq_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (cnt_q[MATCH_W-1:0] == '0));
endmodule

// File: rtl/corectr_top.sv
module corectr_top
  import corectr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned N_CORES = 4,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned MATCH_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [N_CORES*CNT_W-1:0]   count_o,
  output logic [N_CORES-1:0]         irq_o
);
  logic               en;
  logic [PSC_W-1:0]   psc;
  logic [N_CORES-1:0] mask;
  logic               tick;

  corectr_regwin #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .N_CORES(N_CORES)
  ) u_regwin (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .en_o(en), .psc_o(psc), .mask_o(mask)
  );

  corectr_presc u_presc (
    .clk_i, .rst_ni, .en_i(en), .sel_i(psc), .tick_o(tick)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    corectr_counter #(.CNT_W(CNT_W), .MATCH_W(MATCH_W)) u_cnt (
      .clk_i, .rst_ni, .tick_i(tick), .mask_i(mask[c]),
      .cnt_o(count_o[c*CNT_W +: CNT_W]), .irq_o(irq_o[c])
    );

    // R8
    irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> $past(mask[c]));

    if (c > 0) begin : g_lock
      // R4
      cnt_lockstep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_o[c*CNT_W +: CNT_W] == count_o[CNT_W-1:0]);
    end
  end
endmodule

// File: tb/corectr_top_bench.sv
`timescale 1ns/1ps
module corectr_top_bench;
  localparam int NC = 4;
  localparam int CW = 64;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [2:0]     addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic [NC*CW-1:0] count;
  logic [NC-1:0]  irq;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  corectr_top u_corectr_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .count_o(count), .irq_o(irq)
  );

  // behavioural reference
  int          m_idx, m_en, m_sel, m_mask, m_phase;
  longint unsigned m_cnt;
  int          m_irq;

  function automatic int div_of(int sel);
    if (sel == 2) return 2;
    if (sel == 4) return 4;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_en = 0; m_sel = 0; m_mask = 0; m_phase = 0; m_cnt = 0; m_irq = 0;
    end else begin
      bit t;
      t = (m_en != 0) && (m_phase >= div_of(m_sel) - 1);
      m_irq = (t && (m_cnt % 16 == 15)) ? m_mask : 0;
      if (t) m_cnt = m_cnt + 1;
      if (m_en == 0 || t) m_phase = 0; else m_phase = m_phase + 1;
      if (wr_en && addr == 3'd0) begin
        if (m_idx == 'h00) begin m_en = int'(wdata[0]); m_sel = int'(wdata[10:8]); end
        else if (m_idx == 'h30) m_mask = int'(wdata[3:0]);
      end
      if (wr_en && addr == 3'd4) m_idx = int'(wdata[7:0]);
    end
  end

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      for (int c = 0; c < NC; c++)
        chk("R4 R5 per-cycle count", count[c*CW +: CW], m_cnt);
      chk("R7 per-cycle irq", longint'(irq), longint'(m_irq));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string tag, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic run_div(string tag, input logic [31:0] ctl, input int div);
    longint unsigned base;
    wr(3'd0, ctl & 32'hFFFF_FFFE);
    wr(3'd0, ctl);
    base = count[CW-1:0];
    repeat (20) @(negedge clk);
    chk(tag, count[CW-1:0] - base, 20 / div);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 count after reset", count, 0);
    chk("R1 irq after reset", irq, 0);
    rd("R1 index after reset", 3'd4, 32'h0);
    rd("R1 ctrl after reset", 3'd0, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    wr(3'd4, 32'h30);
    rd("R2 index readback", 3'd4, 32'h30);
    rd("R7 mask after reset", 3'd0, 32'h0);
    wr(3'd0, 32'h5);
    rd("R7 mask readback", 3'd0, 32'h5);

    wr(3'd4, 32'hFFFF_FF00);
    rd("R2 index keeps low bits only", 3'd4, 32'h0);
    wr(3'd0, 32'hFFFF_FCFE);
    rd("R3 ctrl drops unused bits", 3'd0, 32'h400);
    repeat (10) @(negedge clk);
    chk("R4 held while disabled", count[CW-1:0], 0);

    run_div("R5 divide by 1", 32'h101, 1);
    run_div("R5 divide by 2", 32'h201, 2);
    run_div("R5 divide by 4", 32'h401, 4);
    run_div("R6 empty select", 32'h001, 1);
    run_div("R6 multi-bit select", 32'h301, 1);

    begin
      int p0, p1, p2, p3;
      p0 = 0; p1 = 0; p2 = 0; p3 = 0;
      wr(3'd0, 32'h101);
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        p0 += int'(irq[0]); p1 += int'(irq[1]); p2 += int'(irq[2]); p3 += int'(irq[3]);
      end
      chk("R7 pulses core0", p0, 4);
      chk("R7 pulses core1 masked", p1, 0);
      chk("R7 pulses core2", p2, 4);
      chk("R7 pulses core3 masked", p3, 0);
    end

    begin
      int seen;
      longint unsigned base;
      seen = 0;
      wr(3'd4, 32'h30);
      wr(3'd0, 32'h0);
      base = count[CW-1:0];
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        seen += int'(|irq);
      end
      chk("R8 no irq when masked", seen, 0);
      chk("R8 counters keep running", count[CW-1:0] - base, 40);
    end

    wr(3'd4, 32'h30);
    wr(3'd0, 32'hA);
    wr(3'd4, 32'h14);
    rd("R9 unmapped read", 3'd0, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd("R9 unmapped read after write", 3'd0, 32'h0);
    wr(3'd4, 32'h30);
    rd("R9 mask unchanged", 3'd0, 32'hA);
    wr(3'd4, 32'h0);
    rd("R9 ctrl unchanged", 3'd0, 32'h101);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule